// File: doc/BRIEF.md
# Packet Interrupt Coalescer

This block decides when a DMA channel interrupts its host. Rather than raising an interrupt on every finished packet, it combines two programmable conditions. A count condition fires once a set number of packets has finished. An idle condition fires when a set amount of time has passed after the most recent packet with no further packet arriving. The idle condition can only fire while at least one packet has finished that no interrupt has yet covered.

The channel's datapath pulses `pkt_done` once for each finished packet. Software programs a packet threshold, an idle delay and an enable mask through a single configuration strobe. Each condition latches a sticky status bit. The interrupt line is high while any enabled status bit is set, and software clears status bits by writing ones to `ack_w1c`. The idle delay is counted in ticks of a prescaler, so a narrow delay field can cover long intervals. The number of packets still needed for the next count interrupt is visible on `thresh_left`.

Top module: `pkt_irq_coalesce`

## Requirements
- R1: After a synchronous reset, `status` is 0, `irq` is 0, the enable mask is 0, the packet threshold is 1 (so `thresh_left` reads 1) and the idle delay is 0.
- R2: Each accepted packet with `thresh_left` above 1 lowers `thresh_left` by one. A packet that arrives while `thresh_left` is 1 sets status bit 0 (the count source) and reloads `thresh_left` with the programmed threshold, all at the same clock edge.
- R3: A `cfg_wr` cycle loads the threshold, the idle delay and the enable mask, and reloads `thresh_left`. A threshold of 0 is stored as 1. A `pkt_done` in the same cycle is ignored, and the write discards any idle-timer progress and any uncovered packet.
- R4: When `pkt_done` was last accepted at clock edge N and no packet or configuration write follows, status bit 1 (the idle source) is set at edge N + delay*PRESCALE and is still clear at the edge before it.
- R5: Every accepted packet restarts the idle timer from zero, so the idle source measures from the latest packet only.
- R6: A packet that sets the count source also cancels the uncovered-packet condition, so no idle interrupt follows it.
- R7: An idle delay of 0 disables the idle source entirely.
- R8: After the idle source has fired, it does not fire again until a new packet is accepted.
- R9: `irq` is high exactly when some status bit is set and the enable bit at the same position is set (bit 0 count, bit 1 idle).
- R10: Writing a one to a bit of `ack_w1c` clears that status bit and leaves the other bit unchanged. If a source event sets the same bit in the same cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pkt_done | input | 1 | One-cycle pulse per finished packet |
| cfg_wr | input | 1 | Configuration load strobe |
| cfg_thresh | input | CNT_W | Packet threshold to load (0 behaves as 1) |
| cfg_delay | input | DLY_W | Idle delay in prescaler ticks (0 disables) |
| cfg_irq_en | input | 2 | Enable mask: bit 0 count, bit 1 idle |
| ack_w1c | input | 2 | Write-one-to-clear for the status bits |
| irq | output | 1 | Interrupt level |
| status | output | 2 | Sticky status: bit 0 count, bit 1 idle |
| thresh_left | output | CNT_W | Packets still needed for the next count interrupt |

## Verification
On every cycle, the assertions check that the remaining count never reads zero and steps down by one per packet. They also check that the count status rises only after an accepted packet, that the idle status never rises in the cycle after a packet, that status bits hold until acknowledged and clear on acknowledgement, and that the interrupt stays low while nothing is pending. Only the bench's scenarios can show the exact cycle at which the idle source fires, and the timer restart on a later packet. The same holds for cancellation by a threshold hit, suppression by a zero delay or by an already covered packet, masking by the enables, and a set beating an acknowledge in the same cycle.

// File: rtl/coal_pkg.sv
package coal_pkg;

    localparam int NUM_SRC = 2;
    localparam int SRC_PKT = 0;
    localparam int SRC_DLY = 1;

    // Per-source event bundle; field order matches the status bit order.
    typedef struct packed {
        logic dly;
        logic pkt;
    } coal_evt_t;

endpackage

// File: rtl/coal_pkt_counter.sv
module coal_pkt_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_wr,
    input  logic [CNT_W-1:0] cfg_thresh,
    input  logic             pkt,
    output logic [CNT_W-1:0] left,
    output logic             hit
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] thr_q;
    logic [CNT_W-1:0] left_q;
    logic [CNT_W-1:0] thr_eff;

    assign thr_eff = (cfg_thresh == '0) ? ONE : cfg_thresh;
    assign hit     = pkt && (left_q == ONE);
    assign left    = left_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            thr_q  <= ONE;
            left_q <= ONE;
        end else if (cfg_wr) begin
            thr_q  <= thr_eff;
            left_q <= thr_eff;
        end else if (pkt) begin
            left_q <= hit ? thr_q : (left_q - ONE);
        end
    end
endmodule

// File: rtl/coal_delay_timer.sv
module coal_delay_timer #(
    parameter int DLY_W    = 8,
    parameter int PRESCALE = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_wr,
    input  logic [DLY_W-1:0] cfg_delay,
    input  logic             pkt,
    input  logic             hit,
    output logic             fire
);
    localparam int PRE_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRESCALE - 1);

    logic [PRE_W-1:0] pre_q;
    logic [DLY_W-1:0] dly_q;
    logic [DLY_W-1:0] cnt_q;
    logic             pend_q;
    logic             tick;
    logic             armed;
    logic [DLY_W:0]   cnt_next;

    assign tick     = (pre_q == PRE_LAST);
    assign armed    = pend_q && (dly_q != '0);
    assign cnt_next = {1'b0, cnt_q} + (DLY_W + 1)'(1);
    assign fire     = armed && tick && !pkt && !cfg_wr && (cnt_next >= {1'b0, dly_q});

    always_ff @(posedge clk) begin
        if (rst) begin
            pre_q  <= '0;
            dly_q  <= '0;
            cnt_q  <= '0;
            pend_q <= 1'b0;
        end else begin
            if (cfg_wr) begin
                dly_q <= cfg_delay;
            end
            if (cfg_wr || pkt) begin
                pre_q  <= '0;
                cnt_q  <= '0;
                pend_q <= pkt && !hit;
            end else begin
                pre_q <= tick ? '0 : (pre_q + PRE_W'(1));
                if (fire) begin
                    pend_q <= 1'b0;
                    cnt_q  <= '0;
                end else if (tick && armed) begin
                    cnt_q <= cnt_q + DLY_W'(1);
                end
            end
        end
    end
endmodule

// File: rtl/coal_status.sv
module coal_status #(
    parameter int NSRC = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cfg_wr,
    input  logic [NSRC-1:0] cfg_en,
    input  logic [NSRC-1:0] set,
    input  logic [NSRC-1:0] ack,
    output logic [NSRC-1:0] status,
    output logic            irq
);
    logic [NSRC-1:0] st_q;
    logic [NSRC-1:0] en_q;

    for (genvar i = 0; i < NSRC; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) begin
                st_q[i] <= 1'b0;
            end else begin
                st_q[i] <= set[i] | (st_q[i] & ~ack[i]);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q <= '0;
        end else if (cfg_wr) begin
            en_q <= cfg_en;
        end
    end

    assign status = st_q;
    assign irq    = |(st_q & en_q);
endmodule

// File: rtl/pkt_irq_coalesce.sv
module pkt_irq_coalesce
    import coal_pkg::*;
#(
    parameter int CNT_W    = 8,
    parameter int DLY_W    = 8,
    parameter int PRESCALE = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               pkt_done,
    input  logic               cfg_wr,
    input  logic [CNT_W-1:0]   cfg_thresh,
    input  logic [DLY_W-1:0]   cfg_delay,
    input  logic [NUM_SRC-1:0] cfg_irq_en,
    input  logic [NUM_SRC-1:0] ack_w1c,
    output logic               irq,
    output logic [NUM_SRC-1:0] status,
    output logic [CNT_W-1:0]   thresh_left
);
    logic      pkt_ok;
    coal_evt_t evt;

    assign pkt_ok = pkt_done && !cfg_wr;

    coal_pkt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst        (rst),
        .cfg_wr     (cfg_wr),
        .cfg_thresh (cfg_thresh),
        .pkt        (pkt_ok),
        .left       (thresh_left),
        .hit        (evt.pkt)
    );

    coal_delay_timer #(.DLY_W(DLY_W), .PRESCALE(PRESCALE)) u_dly (
        .clk       (clk),
        .rst       (rst),
        .cfg_wr    (cfg_wr),
        .cfg_delay (cfg_delay),
        .pkt       (pkt_ok),
        .hit       (evt.pkt),
        .fire      (evt.dly)
    );

    coal_status #(.NSRC(NUM_SRC)) u_st (
        .clk    (clk),
        .rst    (rst),
        .cfg_wr (cfg_wr),
        .cfg_en (cfg_irq_en),
        .set    (evt),
        .ack    (ack_w1c),
        .status (status),
        .irq    (irq)
    );
endmodule

// File: rtl/coal_checker.sv
module coal_checker #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             pkt_done,
    input logic             cfg_wr,
    input logic [1:0]       ack_w1c,
    input logic             irq,
    input logic [1:0]       status,
    input logic [CNT_W-1:0] thresh_left
);
    assert_left_nonzero_R2: assert property (@(posedge clk) disable iff (rst)
        thresh_left != '0);

    assert_left_dec_R2: assert property (@(posedge clk) disable iff (rst)
        (pkt_done && !cfg_wr && thresh_left > CNT_W'(1))
        |=> thresh_left == $past(thresh_left) - CNT_W'(1));

    assert_pkt_src_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(status[0]) |-> $past(pkt_done && !cfg_wr));

    assert_dly_quiet_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(status[1]) |-> !$past(pkt_done));

    assert_sticky_pkt_R10: assert property (@(posedge clk) disable iff (rst)
        (status[0] && !ack_w1c[0]) |=> status[0]);

    assert_sticky_dly_R10: assert property (@(posedge clk) disable iff (rst)
        (status[1] && !ack_w1c[1]) |=> status[1]);

    assert_ack_clear_R10: assert property (@(posedge clk) disable iff (rst)
        (ack_w1c[0] && !pkt_done) |=> !status[0]);

    assert_irq_idle_R9: assert property (@(posedge clk) disable iff (rst)
        (status == 2'b00) |-> !irq);
endmodule

bind pkt_irq_coalesce coal_checker #(.CNT_W(CNT_W)) u_coal_chk (
    .clk         (clk),
    .rst         (rst),
    .pkt_done    (pkt_done),
    .cfg_wr      (cfg_wr),
    .ack_w1c     (ack_w1c),
    .irq         (irq),
    .status      (status),
    .thresh_left (thresh_left)
);

// File: tb/test_pkt_irq_coalesce.sv
`timescale 1ns/1ps
module test_pkt_irq_coalesce;
    localparam int CNT_W = 8;
    localparam int DLY_W = 8;
    localparam int PS    = 4;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             pkt_done = 1'b0;
    logic             cfg_wr = 1'b0;
    logic [CNT_W-1:0] cfg_thresh = '0;
    logic [DLY_W-1:0] cfg_delay = '0;
    logic [1:0]       cfg_irq_en = '0;
    logic [1:0]       ack_w1c = '0;
    logic             irq;
    logic [1:0]       status;
    logic [CNT_W-1:0] thresh_left;

    pkt_irq_coalesce #(.CNT_W(CNT_W), .DLY_W(DLY_W), .PRESCALE(PS)) i_pkt_irq_coalesce (
        .clk(clk), .rst(rst), .pkt_done(pkt_done), .cfg_wr(cfg_wr),
        .cfg_thresh(cfg_thresh), .cfg_delay(cfg_delay), .cfg_irq_en(cfg_irq_en),
        .ack_w1c(ack_w1c), .irq(irq), .status(status), .thresh_left(thresh_left)
    );

    always #2.5 clk = ~clk;

    typedef struct {
        int         cyc;
        logic [1:0] st;
        logic       irq;
        int         left;
        string      tag;
    } exp_t;

    exp_t q[$];
    int   cyc = 0;
    int   checks = 0;
    int   errors = 0;
    int   n = 0;

    // Monitor: after each rising edge, compare every expectation due now.
    always begin
        @(posedge clk);
        cyc = cyc + 1;
        #1;
        while (q.size() > 0 && q[0].cyc <= cyc) begin
            exp_t e;
            e = q.pop_front();
            checks++;
            if (e.cyc < cyc) begin
                errors++;
                $display("FAIL %s: expectation for cycle %0d missed (now %0d)", e.tag, e.cyc, cyc);
            end else if (status !== e.st || irq !== e.irq || int'(thresh_left) != e.left) begin
                errors++;
                $display("FAIL %s cyc %0d: status=%b irq=%b left=%0d expected status=%b irq=%b left=%0d",
                         e.tag, cyc, status, irq, thresh_left, e.st, e.irq, e.left);
            end
        end
    end

    task automatic expect_at(input int c, input logic [1:0] st, input logic ir,
                             input int left, input string tag);
        exp_t e;
        e.cyc = c; e.st = st; e.irq = ir; e.left = left; e.tag = tag;
        q.push_back(e);
    endtask

    // All driver tasks start and end at a falling edge.
    task automatic idle(input int k);
        repeat (k) @(negedge clk);
    endtask

    task automatic cfg(input int thr, input int dly, input logic [1:0] en, input logic with_pkt,
                       input logic [1:0] st, input logic ir, input int left, input string tag);
        expect_at(cyc + 1, st, ir, left, tag);
        cfg_thresh = CNT_W'(thr); cfg_delay = DLY_W'(dly); cfg_irq_en = en;
        cfg_wr = 1'b1; pkt_done = with_pkt;
        @(negedge clk);
        cfg_wr = 1'b0; pkt_done = 1'b0;
    endtask

    task automatic pulse(input logic [1:0] ack, input logic [1:0] st, input logic ir,
                         input int left, input string tag, output int edge_n);
        edge_n = cyc + 1;
        expect_at(edge_n, st, ir, left, tag);
        pkt_done = 1'b1; ack_w1c = ack;
        @(negedge clk);
        pkt_done = 1'b0; ack_w1c = 2'b00;
    endtask

    task automatic ack(input logic [1:0] bits, input logic [1:0] st, input logic ir,
                       input int left, input string tag);
        expect_at(cyc + 1, st, ir, left, tag);
        ack_w1c = bits;
        @(negedge clk);
        ack_w1c = 2'b00;
    endtask

    initial begin
        expect_at(1, 2'b00, 1'b0, 1, "R1 reset");
        idle(3);
        rst = 1'b0;
        expect_at(cyc + 1, 2'b00, 1'b0, 1, "R1 after release");
        idle(2);

        // R2 with the reset threshold of 1 and all enables clear (R1, R9)
        pulse(2'b00, 2'b01, 1'b0, 1, "R2 default threshold", n);
        ack(2'b01, 2'b00, 1'b0, 1, "R10 clear count bit");

        // R3 load, R2 counting down to the hit, R9 enabled count irq
        cfg(3, 0, 2'b01, 1'b0, 2'b00, 1'b0, 3, "R3 load threshold");
        pulse(2'b00, 2'b00, 1'b0, 2, "R2 step 3->2", n);
        pulse(2'b00, 2'b00, 1'b0, 1, "R2 step 2->1", n);
        pulse(2'b00, 2'b01, 1'b1, 3, "R2 hit reload, R9 irq", n);
        ack(2'b01, 2'b00, 1'b0, 3, "R10 ack drops irq");

        // R7: zero delay, uncovered packet never times out
        pulse(2'b00, 2'b00, 1'b0, 2, "R7 packet", n);
        expect_at(n + 100, 2'b00, 1'b0, 2, "R7 zero delay silent");
        idle(101);

        // R4 exact firing edge, R8 no second fire
        cfg(3, 5, 2'b11, 1'b0, 2'b00, 1'b0, 3, "R3 reload on write");
        pulse(2'b00, 2'b00, 1'b0, 2, "R4 packet", n);
        expect_at(n + 5 * PS - 1, 2'b00, 1'b0, 2, "R4 one edge early");
        expect_at(n + 5 * PS, 2'b10, 1'b1, 2, "R4 idle fire");
        idle(5 * PS + 2);
        ack(2'b10, 2'b00, 1'b0, 2, "R10 clear idle bit");
        expect_at(cyc + 60, 2'b00, 1'b0, 2, "R8 no refire");
        idle(61);

        // R5 restart on a later packet
        cfg(5, 5, 2'b11, 1'b0, 2'b00, 1'b0, 5, "R3 load 5");
        pulse(2'b00, 2'b00, 1'b0, 4, "R5 first packet", n);
        idle(11);
        begin
            int n1;
            n1 = n;
            pulse(2'b00, 2'b00, 1'b0, 3, "R5 second packet", n);
            expect_at(n1 + 5 * PS, 2'b00, 1'b0, 3, "R5 old deadline ignored");
        end
        expect_at(n + 5 * PS - 1, 2'b00, 1'b0, 3, "R5 new deadline early");
        expect_at(n + 5 * PS, 2'b10, 1'b1, 3, "R5 new deadline fire");
        idle(5 * PS + 2);
        ack(2'b10, 2'b00, 1'b0, 3, "R10 clear idle bit again");

        // R6 threshold hit cancels the idle source
        cfg(2, 5, 2'b11, 1'b0, 2'b00, 1'b0, 2, "R3 load 2");
        pulse(2'b00, 2'b00, 1'b0, 1, "R6 first", n);
        pulse(2'b00, 2'b01, 1'b1, 2, "R6 hit", n);
        expect_at(n + 30, 2'b01, 1'b1, 2, "R6 no idle after hit");
        idle(31);
        ack(2'b01, 2'b00, 1'b0, 2, "R10 clear");

        // R9 masking: idle fires with only count enabled
        cfg(2, 3, 2'b01, 1'b0, 2'b00, 1'b0, 2, "R3 mask count only");
        pulse(2'b00, 2'b00, 1'b0, 1, "R9 packet", n);
        expect_at(n + 3 * PS, 2'b10, 1'b0, 1, "R9 masked idle bit");
        idle(3 * PS + 2);
        // R10: ack both bits while a hit sets bit 0 in the same cycle
        pulse(2'b11, 2'b01, 1'b1, 2, "R10 set beats ack", n);
        ack(2'b01, 2'b00, 1'b0, 2, "R10 clear");

        // R3 zero threshold acts as 1, and a packet during a write is ignored
        cfg(0, 0, 2'b00, 1'b0, 2'b00, 1'b0, 1, "R3 zero as one");
        pulse(2'b00, 2'b01, 1'b0, 1, "R3 zero threshold hit", n);
        ack(2'b01, 2'b00, 1'b0, 1, "R10 clear");
        cfg(4, 0, 2'b00, 1'b1, 2'b00, 1'b0, 4, "R3 packet with write ignored");
        pulse(2'b00, 2'b00, 1'b0, 3, "R3 next packet counts", n);

        idle(3);
        if (q.size() != 0) begin
            errors++;
            $display("FAIL scoreboard: %0d expectations left unchecked", q.size());
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #1000000;
        errors++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule